// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller with Secondary Sources

This block gathers interrupt requests from peripherals and hands each of up to four processors a single prioritised interrupt level from 1 to 15. Level 0 means that nothing is pending for that processor. A rising edge on a request input makes its level pending. The level stays pending until a processor acknowledges it or software clears it. Each processor has its own enable mask. Level 15 always gets through, whatever the mask holds.

Sixteen optional secondary request lines (sources 16 to 31) share one primary level, set by the parameter `SEC_LEVEL`. `SEC_LEVEL` must lie between 1 and 14. While secondary sources are enabled, the primary input at that level is not used. A secondary-identify register names the lowest-numbered pending secondary source, and writing that register retires the source it names.

A broadcast register controls how each level is delivered:
- A level marked broadcast is delivered to every processor, and each processor keeps and retires its own copy.
- An unmarked level is shared, and the first acknowledge from any processor clears it.

Software reaches the block through a simple single-cycle register port with a write strobe and a combinational read.

Top module: `mpic_top`

## Requirements
- R1: After reset, every shared pending bit, broadcast copy, secondary pending bit, mask and broadcast bit is 0, every processor level reads 0, and a read of address 0 returns 0.
- R2: A 0-to-1 transition on `irq_in[l]` (l = 1..15) makes level l pending at the next rising clock edge. An input held high pends its level only once, so after it is acknowledged it stays clear. Address 0 reads the shared pending bits on bits 15:1.
- R3: Each processor's 4-bit slice `cpu_level[4c+3:4c]` equals the highest level l whose shared pending bit or processor-c broadcast copy is set and which is enabled in that processor's mask. The slice is 0 when no level qualifies.
- R4: Level 15 is presented to every processor whose pending state holds it, even when bit 15 of that processor's mask is 0.
- R5: With `SEC_EN` = 1, a rising edge on `irq_in[16+j]` sets secondary pending bit j, read on bits 31:16 of address 4, and raises an event at level `SEC_LEVEL`. An edge on the primary `irq_in[SEC_LEVEL]` has no effect.
- R6: A read of address 5 returns 16+j, where j is the lowest pending secondary bit, or 0 when no secondary bit is pending. A write of any value to address 5 clears exactly that bit.
- R7: For a level with its broadcast bit at 0, an acknowledge (`ack_valid[c]` with level l in `ack_level[4c+3:4c]`) from any processor clears the shared pending bit, so it disappears for all processors. Acknowledge level 0 is ignored.
- R8: For a level whose bit is set in the broadcast register (address 3, bits 15:1), an event sets a private copy for every processor. An acknowledge clears only the acknowledging processor's copy.
- R9: A write to address 1 raises an event at each level whose write bit (15:1) is 1. A write to address 2 clears the shared pending bit and all broadcast copies of each level whose write bit is 1.
- R10: When an event and a clear or acknowledge hit the same level in the same cycle, the level ends up pending.
- R11: The mask of processor c is read and written at address 8+c on bits 15:1, and the broadcast register is read and written at address 3. Writes take effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 32 | Request lines: 15:1 primary, 31:16 secondary, bit 0 unused |
| reg_addr | input | AW | Register address |
| reg_we | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| ack_valid | input | NCPU | Acknowledge strobe per processor |
| ack_level | input | 4*NCPU | Acknowledged level per processor |
| cpu_level | output | 4*NCPU | Presented interrupt level per processor |

## Verification
Every output level depends directly on the stored pending, copy and mask state. A pending bit that is lost, duplicated or routed to the wrong place therefore shows on some processor's level in the cycle after the faulty update, as long as that level is the highest enabled one. A shared-versus-broadcast routing error stays hidden until a second processor looks at the same level. For that reason the stimulus acknowledges broadcast levels from one processor and watches the others. A wrong secondary pending bit shows immediately on the identify and secondary pending reads. The bench compares every processor level and the current read data against a behavioural model on every clock.

// File: rtl/mpic_pkg.sv
package mpic_pkg;
    localparam int LVL_W     = 4;
    localparam int NLVL      = 16;
    localparam int NSEC      = 16;
    localparam int A_PEND    = 0;
    localparam int A_FORCE   = 1;
    localparam int A_CLEAR   = 2;
    localparam int A_BCAST   = 3;
    localparam int A_SECPEND = 4;
    localparam int A_SECID   = 5;
    localparam int A_MASK0   = 8;
    typedef logic [NLVL-1:0] lvl_vec_t;
endpackage

// File: rtl/mpic_edge_det.sv
module mpic_edge_det #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= din;
    end

    assign rise = din & ~prev_q;
endmodule

// File: rtl/mpic_prio_enc.sv
module mpic_prio_enc #(
    parameter int W          = 16,
    parameter bit HIGH_FIRST = 1'b1,
    localparam int IW        = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          hit
);
    always_comb begin
        idx = '0;
        hit = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[HIGH_FIRST ? i : W-1-i]) begin
                idx = IW'(HIGH_FIRST ? i : W-1-i);
                hit = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mpic_top.sv
module mpic_top
    import mpic_pkg::*;
#(
    parameter int NCPU      = 4,
    parameter bit SEC_EN    = 1'b1,
    parameter int SEC_LEVEL = 12,
    parameter int AW        = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [31:0]           irq_in,
    input  logic [AW-1:0]         reg_addr,
    input  logic                  reg_we,
    input  logic [15:0]           reg_wdata,
    output logic [31:0]           reg_rdata,
    input  logic [NCPU-1:0]       ack_valid,
    input  logic [LVL_W*NCPU-1:0] ack_level,
    output logic [LVL_W*NCPU-1:0] cpu_level
);
    localparam lvl_vec_t LVL_MASK = 16'hFFFE;
    localparam lvl_vec_t TOP_LVL  = 16'h8000;

    lvl_vec_t pend_q, bcast_q, sec_q;
    lvl_vec_t mask_q [NCPU];
    lvl_vec_t copy_q [NCPU];
    lvl_vec_t ack_vec [NCPU];
    lvl_vec_t pri_rise, sec_rise, evt, frc_w, clr_w, ack_any, sec_clr;
    logic [31:0] rise_w;
    logic [3:0]  sec_idx;
    logic        sec_hit;

    mpic_edge_det #(.W(32)) u_edge (
        .clk(clk), .rst_n(rst_n), .din(irq_in), .rise(rise_w)
    );

    mpic_prio_enc #(.W(NSEC), .HIGH_FIRST(1'b0)) u_sec_pick (
        .vec(sec_q), .idx(sec_idx), .hit(sec_hit)
    );

    // event collection
    always_comb begin
        pri_rise = rise_w[15:0] & LVL_MASK;
        sec_rise = '0;
        if (SEC_EN) begin
            pri_rise[SEC_LEVEL] = 1'b0;
            sec_rise = rise_w[31:16];
        end
        frc_w = (reg_we && reg_addr == AW'(A_FORCE)) ? (reg_wdata & LVL_MASK) : '0;
        clr_w = (reg_we && reg_addr == AW'(A_CLEAR)) ? (reg_wdata & LVL_MASK) : '0;
        evt = pri_rise | frc_w | ((|sec_rise) ? (lvl_vec_t'(1) << SEC_LEVEL) : '0);
        sec_clr = (reg_we && reg_addr == AW'(A_SECID) && sec_hit)
                  ? (lvl_vec_t'(1) << sec_idx) : '0;
        ack_any = '0;
        for (int c = 0; c < NCPU; c++) ack_any = ack_any | ack_vec[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q  <= '0;
            bcast_q <= '0;
            sec_q   <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_w & ~ack_any) | (evt & ~bcast_q);
            sec_q  <= (sec_q & ~sec_clr) | sec_rise;
            if (reg_we && reg_addr == AW'(A_BCAST)) bcast_q <= reg_wdata & LVL_MASK;
        end
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [LVL_W-1:0] ack_l, lvl_idx;
        logic             lvl_hit;
        lvl_vec_t         eligible;

        assign ack_l      = ack_level[LVL_W*c +: LVL_W];
        assign ack_vec[c] = (ack_valid[c] && ack_l != '0) ? (lvl_vec_t'(1) << ack_l) : '0;
        assign eligible   = (pend_q | copy_q[c]) & (mask_q[c] | TOP_LVL);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                copy_q[c] <= '0;
                mask_q[c] <= '0;
            end else begin
                copy_q[c] <= (copy_q[c] & ~clr_w & ~ack_vec[c]) | (evt & bcast_q);
                if (reg_we && reg_addr == AW'(A_MASK0 + c)) mask_q[c] <= reg_wdata & LVL_MASK;
            end
        end

        mpic_prio_enc #(.W(NLVL), .HIGH_FIRST(1'b1)) u_pick (
            .vec(eligible), .idx(lvl_idx), .hit(lvl_hit)
        );
        assign cpu_level[LVL_W*c +: LVL_W] = lvl_hit ? lvl_idx : '0;

        // R4: level 15 reaches the processor regardless of its mask
        a_r4_top_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
            pend_q[15] |-> cpu_level[LVL_W*c +: LVL_W] == 4'd15);
        // R3: a presented level is pending and enabled for this processor
        a_r3_level_enabled: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_level[LVL_W*c +: LVL_W] != '0 |->
                eligible[cpu_level[LVL_W*c +: LVL_W]]);

        for (genvar l = 1; l < NLVL; l++) begin : g_lvl
            // R7: acknowledge without a new event retires the level for this processor
            a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
                (ack_valid[c] && ack_l == LVL_W'(l) && !evt[l]) |=>
                    (!pend_q[l] && !copy_q[c][l]));
            // R8 / R10: a broadcast event lands in every copy, winning over clears
            a_r8_bcast_copy: assert property (@(posedge clk) disable iff (!rst_n)
                (evt[l] && bcast_q[l]) |=> copy_q[c][l]);
        end
    end

    for (genvar l = 1; l < NLVL; l++) begin : g_shared
        // R10: a shared event wins over a same-cycle clear or acknowledge
        a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (evt[l] && !bcast_q[l]) |=> pend_q[l]);
    end

    // R6: the identified secondary source is the lowest pending one
    a_r6_lowest_sec: assert property (@(posedge clk) disable iff (!rst_n)
        sec_hit |-> (sec_q[sec_idx] && ((sec_q & ((lvl_vec_t'(1) << sec_idx) - 1'b1)) == '0)));

    // register read port
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            AW'(A_PEND):    reg_rdata = {16'h0, pend_q};
            AW'(A_BCAST):   reg_rdata = {16'h0, bcast_q};
            AW'(A_SECPEND): reg_rdata = {sec_q, 16'h0};
            AW'(A_SECID):   reg_rdata = sec_hit ? {27'h0, 1'b1, sec_idx} : 32'h0;
            default:        reg_rdata = '0;
        endcase
        for (int c = 0; c < NCPU; c++)
            if (reg_addr == AW'(A_MASK0 + c)) reg_rdata = {16'h0, mask_q[c]};
    end
endmodule

// File: tb/mpic_top_tb.sv
module mpic_top_tb_top;
    localparam int NCPU = 4;
    localparam int SECL = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic [3:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [NCPU-1:0]   ack_valid = '0;
    logic [4*NCPU-1:0] ack_level = '0;
    logic [4*NCPU-1:0] cpu_level;

    int    total = 0;
    int    bad = 0;
    bit    live = 0;
    bit    done = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    mpic_top #(.NCPU(NCPU), .SEC_EN(1'b1), .SEC_LEVEL(SECL), .AW(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ack_valid(ack_valid), .ack_level(ack_level), .cpu_level(cpu_level)
    );

    // behavioural reference model
    bit [15:0] m_pend = '0, m_bcast = '0, m_sec = '0;
    bit [15:0] m_mask [NCPU];
    bit [15:0] m_copy [NCPU];
    bit [31:0] m_prev = '0;
    bit [31:0] t_rise;
    bit [15:0] t_evt, t_clr, t_all;
    bit [15:0] t_ack [NCPU];

    initial for (int c = 0; c < NCPU; c++) begin m_mask[c] = '0; m_copy[c] = '0; end

    function automatic int low_sec();
        for (int j = 0; j < 16; j++) if (m_sec[j]) return j;
        return -1;
    endfunction

    function automatic int exp_level(int c);
        for (int l = 15; l >= 1; l--)
            if ((m_pend[l] || m_copy[c][l]) && (m_mask[c][l] || l == 15)) return l;
        return 0;
    endfunction

    function automatic bit [31:0] exp_read(int a);
        if (a == 0) return {16'h0, m_pend};
        if (a == 3) return {16'h0, m_bcast};
        if (a == 4) return {m_sec, 16'h0};
        if (a == 5) return (low_sec() < 0) ? 32'h0 : 32'(16 + low_sec());
        if (a >= 8 && a < 8 + NCPU) return {16'h0, m_mask[a-8]};
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_bcast = '0; m_sec = '0; m_prev = '0;
            for (int c = 0; c < NCPU; c++) begin m_mask[c] = '0; m_copy[c] = '0; end
        end else begin
            t_rise = irq_in & ~m_prev;
            m_prev = irq_in;
            t_evt = '0; t_clr = '0; t_all = '0;
            for (int l = 1; l < 16; l++) if (t_rise[l] && l != SECL) t_evt[l] = 1'b1;
            if (t_rise[31:16] != 0) t_evt[SECL] = 1'b1;
            if (reg_we && reg_addr == 4'd1)
                for (int l = 1; l < 16; l++) if (reg_wdata[l]) t_evt[l] = 1'b1;
            if (reg_we && reg_addr == 4'd2)
                for (int l = 1; l < 16; l++) if (reg_wdata[l]) t_clr[l] = 1'b1;
            for (int c = 0; c < NCPU; c++) begin
                t_ack[c] = '0;
                if (ack_valid[c] && ack_level[4*c +: 4] != 0) t_ack[c][ack_level[4*c +: 4]] = 1'b1;
                t_all = t_all | t_ack[c];
            end
            for (int l = 1; l < 16; l++) begin
                if (t_clr[l] || t_all[l]) m_pend[l] = 1'b0;
                for (int c = 0; c < NCPU; c++) begin
                    if (t_clr[l] || t_ack[c][l]) m_copy[c][l] = 1'b0;
                    if (t_evt[l] && m_bcast[l]) m_copy[c][l] = 1'b1;
                end
                if (t_evt[l] && !m_bcast[l]) m_pend[l] = 1'b1;
            end
            if (reg_we && reg_addr == 4'd5 && low_sec() >= 0) m_sec[low_sec()] = 1'b0;
            m_sec = m_sec | t_rise[31:16];
            if (reg_we && reg_addr == 4'd3) m_bcast = reg_wdata & 16'hFFFE;
            for (int c = 0; c < NCPU; c++)
                if (reg_we && reg_addr == 4'(8 + c)) m_mask[c] = reg_wdata & 16'hFFFE;
        end
    end

    // per-clock comparison against the model
    always @(posedge clk) begin
        #1;
        if (live) begin
            for (int c = 0; c < NCPU; c++) begin
                total++;
                if (int'(cpu_level[4*c +: 4]) != exp_level(c)) begin
                    bad++;
                    $display("FAIL R3 cpu%0d level actual=%0d expected=%0d", c,
                             cpu_level[4*c +: 4], exp_level(c));
                end
            end
            total++;
            if (reg_rdata !== exp_read(int'(reg_addr))) begin
                bad++;
                $display("FAIL %s read addr=%0d actual=%h expected=%h", cur_req,
                         reg_addr, reg_rdata, exp_read(int'(reg_addr)));
            end
        end
    end

    task automatic chk(string req, int act, int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int lvl(int c);
        return int'(cpu_level[4*c +: 4]);
    endfunction

    task automatic wr(int a, int d);
        @(negedge clk); reg_addr = 4'(a); reg_we = 1'b1; reg_wdata = 16'(d);
        @(negedge clk); reg_we = 1'b0; #1;
    endtask

    task automatic rd(int a, output int v);
        @(negedge clk); reg_addr = 4'(a); #1; v = int'(reg_rdata);
    endtask

    task automatic ack(int c, int l);
        @(negedge clk); ack_valid[c] = 1'b1; ack_level[4*c +: 4] = 4'(l);
        @(negedge clk); ack_valid[c] = 1'b0; #1;
    endtask

    task automatic pulse(int b);
        @(negedge clk); irq_in[b] = 1'b1;
        @(negedge clk); irq_in[b] = 1'b0; #1;
    endtask

    initial begin
        int v;
        repeat (3) @(negedge clk);
        #1;
        cur_req = "R1";
        for (int c = 0; c < NCPU; c++) chk("R1 reset level", lvl(c), 0);
        chk("R1 reset pend read", int'(reg_rdata), 0);
        rst_n = 1'b1;
        live = 1'b1;
        @(negedge clk);

        cur_req = "R11";
        wr(8, 16'hFFFE); wr(9, 16'h00F0); wr(10, 0); wr(11, 16'hFFFE);
        rd(9, v); chk("R11 mask1 readback", v, 16'h00F0);

        cur_req = "R2";
        @(negedge clk); irq_in[5] = 1'b1;
        @(negedge clk); #1;
        chk("R2 cpu0 sees 5", lvl(0), 5);
        chk("R2 cpu1 sees 5", lvl(1), 5);
        chk("R2 cpu2 masked", lvl(2), 0);
        ack(0, 5);
        repeat (2) @(negedge clk);
        rd(0, v); chk("R2 held input pends once", v, 0);
        irq_in[5] = 1'b0;

        cur_req = "R3";
        pulse(3); pulse(7);
        chk("R3 cpu0 highest", lvl(0), 7);
        chk("R3 cpu1 highest enabled", lvl(1), 7);

        cur_req = "R7";
        ack(1, 7);
        chk("R7 cpu0 after shared ack", lvl(0), 3);
        chk("R7 cpu1 after shared ack", lvl(1), 0);
        ack(2, 0);
        chk("R7 ack level 0 ignored", lvl(0), 3);

        cur_req = "R4";
        pulse(15);
        chk("R4 cpu2 unmasked 15", lvl(2), 15);

        cur_req = "R9";
        wr(2, 16'h8008);
        chk("R9 clear removes 15 and 3", lvl(0), 0);

        cur_req = "R8";
        wr(3, 16'h0200); pulse(9);
        chk("R8 cpu0 copy", lvl(0), 9);
        chk("R8 cpu3 copy", lvl(3), 9);
        ack(0, 9);
        chk("R8 cpu0 retired", lvl(0), 0);
        chk("R8 cpu3 kept", lvl(3), 9);

        cur_req = "R9";
        wr(1, 16'h0040);
        chk("R9 force cpu1", lvl(1), 6);
        wr(2, 16'h0240);
        chk("R9 clear all cpu3", lvl(3), 0);

        cur_req = "R5";
        pulse(SECL);
        rd(0, v); chk("R5 primary at secondary level ignored", v, 0);
        pulse(20); pulse(17);
        rd(4, v); chk("R5 secondary pending", v, 32'h0012_0000);
        chk("R5 cpu0 at secondary level", lvl(0), SECL);

        cur_req = "R6";
        rd(5, v); chk("R6 lowest id", v, 17);
        wr(5, 0); rd(5, v); chk("R6 next id", v, 20);
        wr(5, 0); rd(5, v); chk("R6 none", v, 0);

        cur_req = "R10";
        @(negedge clk); irq_in[8] = 1'b1; reg_addr = 4'd2; reg_we = 1'b1; reg_wdata = 16'h0100;
        @(negedge clk); reg_we = 1'b0; irq_in[8] = 1'b0;
        rd(0, v); chk("R10 event beats clear", v & 16'h0100, 16'h0100);
        repeat (3) @(negedge clk);

        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule